// File: doc/BRIEF.md
# Bus data parity error signaller

This block belongs to a bus agent on a shared parallel bus. It decides when the agent drives the shared active-low data-parity-error line, and it controls the tri-state driver for that line. Each data clock, the agent's parity checker reports a pass or fail result for the data that came one clock earlier. The block combines that result with the IRDY#/TRDY# handshake, the agent's role, the transfer direction, the special-cycle flag and the error-response enable. From these it places the error pulse on the exact clock the bus protocol requires.

The block latches the transaction context when the address phase starts. From that point it counts clocks until the driver may be switched on. That count depends on whether the address phase is one or two clocks long. For a target, the driver also waits until the target has claimed the transaction with DEVSEL#. The block holds an early-reported error until the data phase has completed. At the end of the transaction it drives the line high for exactly one clock and then releases it.

Top module: `perr_signaller`

## Requirements
- R1: When `resp_en` is 0 on a clock, `perr_n_o` is 1 on the next clock, whatever the parity results.
- R2: Errors are reported only by the receiver of the data. That is a master (`is_master`=1) on a read (`is_write`=0), or a target (`is_master`=0) on a write (`is_write`=1). A master on a write and a target on a read never pull the line low.
- R3: A transaction latched with `special_cycle`=1 never pulls the line low.
- R4: A data phase completes on a clock edge where `irdy_n` and `trdy_n` are both 0. `par_bad`=1 on the edge after it marks that data as bad. For a bad data phase with no wait states, `perr_n_o` is 0 when sampled at the second edge after completion.
- R5: If the receiver is waiting and the sender's ready signal is low, the data counts as valid. The sender's ready is `irdy_n` for a target on a write, and `trdy_n` for a master on a read. A bad result for valid data pulls the line low at the second edge after that data-valid edge, before the transfer completes.
- R6: Once pulled low for a data phase, the line stays low through the second edge after that phase completes, even if later parity results are good.
- R7: In a burst with no wait states, each completed phase is reported on its own clock. Good phases between bad ones read high.
- R8: `ad_turn`=1 marks the address/data bus turnaround clock at the end of the transaction. The line is driven high at the second edge after it, and `perr_oe` is 0 from the third edge on.
- R9: `txn_start`=1 marks the first address clock, and `dual_addr`=1 makes the address phase two clocks long. For a master, `perr_oe` first reads 1 at the third edge after the last address clock.
- R10: A target does not enable the driver before the edge after the one where it first sampled `devsel_n`=0. It also never enables it earlier than R9 allows.
- R11: After reset, and while idle, `perr_oe` is 0 and `perr_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_start | input | 1 | First address clock of a transaction |
| dual_addr | input | 1 | 1 = two-clock address phase |
| is_master | input | 1 | 1 = agent is master, 0 = target |
| is_write | input | 1 | 1 = write transfer, 0 = read |
| special_cycle | input | 1 | 1 = broadcast special cycle |
| resp_en | input | 1 | Parity error response enable |
| irdy_n | input | 1 | Sampled initiator ready, active low |
| trdy_n | input | 1 | Sampled target ready, active low |
| devsel_n | input | 1 | Sampled device select, active low |
| par_bad | input | 1 | Parity check failed for the previous clock's data |
| ad_turn | input | 1 | Address/data bus turnaround clock ending the transaction |
| perr_n_o | output | 1 | Value driven on the error line, active low |
| perr_oe | output | 1 | Tri-state enable for the error line |

## Verification
The main path is driven with four data-phase patterns. A single zero-wait phase pins the two-edge latency. A zero-wait burst with a good phase between two bad ones shows that each phase is reported separately. A target-side wait and a master-side wait, with the bad parity seen only on the first valid clock, tell early assertion apart from the hold that lasts to completion. The same single phase is then repeated with the enable clear, with the non-receiving role and direction pairs, and as a special cycle, to show the line stays high. Dual address and slow decode cases locate the first enabled edge, and every case follows the one-clock high and the release.

// File: rtl/perr_pkg.sv
`timescale 1ns/1ps
package perr_pkg;

   typedef enum logic [2:0] {
      W_IDLE,
      W_ADDR2,
      W_GAP,
      W_ACTIVE,
      W_DRAIN,
      W_ENDHI
   } win_state_t;

   typedef struct packed {
      logic master;
      logic write;
      logic special;
   } txn_ctx_t;

endpackage

// File: rtl/perr_ctx_reg.sv
`timescale 1ns/1ps
module perr_ctx_reg
   import perr_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     load,
   input  logic     is_master,
   input  logic     is_write,
   input  logic     special_cycle,
   output txn_ctx_t ctx
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctx <= '0;
      end else if (load) begin
         ctx.master  <= is_master;
         ctx.write   <= is_write;
         ctx.special <= special_cycle;
      end
   end

endmodule

// File: rtl/perr_window.sv
`timescale 1ns/1ps
module perr_window
   import perr_pkg::*;
#(
   parameter int unsigned MIN_GAP_CLKS = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic txn_start,
   input  logic dual_addr,
   input  logic is_master,
   input  logic devsel_n,
   input  logic ad_turn,
   output logic idle,
   output logic live,
   output logic drive_en,
   output logic report_en
);

   localparam int unsigned CNT_W = $clog2(MIN_GAP_CLKS + 1);
   localparam logic [CNT_W-1:0] GAP_DONE = CNT_W'(MIN_GAP_CLKS - 2);

   generate
      if (MIN_GAP_CLKS < 3) begin : g_bad_gap
         $error("perr_window: MIN_GAP_CLKS must be at least 3");
      end
   endgenerate

   win_state_t       state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             devsel_seen_q, devsel_seen_d;
   logic             claim_ok, gap_ok;

   assign gap_ok   = (cnt_q == GAP_DONE);
   assign claim_ok = is_master || devsel_seen_q || !devsel_n;

   always_comb begin
      state_d       = state_q;
      cnt_d         = cnt_q;
      devsel_seen_d = devsel_seen_q;
      unique case (state_q)
         W_IDLE: begin
            if (txn_start) begin
               state_d       = dual_addr ? W_ADDR2 : W_GAP;
               cnt_d         = '0;
               devsel_seen_d = 1'b0;
            end
         end
         W_ADDR2: begin
            state_d       = W_GAP;
            cnt_d         = '0;
            devsel_seen_d = devsel_seen_q || !devsel_n;
         end
         W_GAP: begin
            devsel_seen_d = devsel_seen_q || !devsel_n;
            if (gap_ok && claim_ok) begin
               state_d = ad_turn ? W_DRAIN : W_ACTIVE;
            end else if (ad_turn) begin
               state_d = W_IDLE;
            end else if (!gap_ok) begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         W_ACTIVE: begin
            if (ad_turn) state_d = W_DRAIN;
         end
         W_DRAIN:  state_d = W_ENDHI;
         W_ENDHI:  state_d = W_IDLE;
         default:  state_d = W_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q       <= W_IDLE;
         cnt_q         <= '0;
         devsel_seen_q <= 1'b0;
      end else begin
         state_q       <= state_d;
         cnt_q         <= cnt_d;
         devsel_seen_q <= devsel_seen_d;
      end
   end

   assign idle      = (state_q == W_IDLE);
   assign live      = state_q inside {W_GAP, W_ACTIVE, W_DRAIN};
   assign drive_en  = state_q inside {W_ACTIVE, W_DRAIN, W_ENDHI};
   assign report_en = state_q inside {W_ACTIVE, W_DRAIN};

   // R9: two clocks after an accepted start the driver is still off
   assert_no_early_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_start && state_q == W_IDLE) |=> !drive_en ##1 !drive_en);

   // R10: a target only drives once it has claimed the transaction
   assert_target_claimed_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_en && !is_master) |-> devsel_seen_q);

endmodule

// File: rtl/perr_detect.sv
`timescale 1ns/1ps
module perr_detect
   import perr_pkg::*;
#(
   parameter bit EARLY_ASSERT = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     clr,
   input  logic     live,
   input  txn_ctx_t ctx,
   input  logic     resp_en,
   input  logic     irdy_n,
   input  logic     trdy_n,
   input  logic     par_bad,
   output logic     assert_q
);

   logic rx_ok, done_now, seen_now;
   logic vld_q, cmp_q, sticky_q, err_now;

   assign rx_ok    = (ctx.master ^ ctx.write) && !ctx.special;
   assign done_now = !irdy_n && !trdy_n;

   generate
      if (EARLY_ASSERT) begin : g_early
         assign seen_now = ctx.master ? !trdy_n : !irdy_n;
      end else begin : g_late
         assign seen_now = done_now;
      end
   endgenerate

   assign err_now = par_bad && vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q    <= 1'b0;
         cmp_q    <= 1'b0;
         sticky_q <= 1'b0;
         assert_q <= 1'b0;
      end else if (clr) begin
         vld_q    <= 1'b0;
         cmp_q    <= 1'b0;
         sticky_q <= 1'b0;
         assert_q <= 1'b0;
      end else begin
         vld_q    <= live && rx_ok && seen_now;
         cmp_q    <= live && done_now;
         assert_q <= resp_en && (err_now || sticky_q);
         if (cmp_q)        sticky_q <= 1'b0;
         else if (err_now) sticky_q <= 1'b1;
      end
   end

   // R6: an error indication only ends after the data phase completed
   assert_hold_to_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(assert_q) && $past(resp_en) && !$past(clr) && !$past(clr, 2))
      |-> $past(cmp_q, 2));

endmodule

// File: rtl/perr_signaller.sv
`timescale 1ns/1ps
module perr_signaller
   import perr_pkg::*;
#(
   parameter int unsigned MIN_GAP_CLKS = 3,
   parameter bit          EARLY_ASSERT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic txn_start,
   input  logic dual_addr,
   input  logic is_master,
   input  logic is_write,
   input  logic special_cycle,
   input  logic resp_en,
   input  logic irdy_n,
   input  logic trdy_n,
   input  logic devsel_n,
   input  logic par_bad,
   input  logic ad_turn,
   output logic perr_n_o,
   output logic perr_oe
);

   txn_ctx_t ctx;
   logic     idle, live, drive_en, report_en, err_q, start_ok;

   assign start_ok = txn_start && idle;

   perr_ctx_reg u_ctx (
      .clk          (clk),
      .rst_n        (rst_n),
      .load         (start_ok),
      .is_master    (is_master),
      .is_write     (is_write),
      .special_cycle(special_cycle),
      .ctx          (ctx)
   );

   perr_window #(.MIN_GAP_CLKS(MIN_GAP_CLKS)) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .txn_start(txn_start),
      .dual_addr(dual_addr),
      .is_master(ctx.master),
      .devsel_n (devsel_n),
      .ad_turn  (ad_turn),
      .idle     (idle),
      .live     (live),
      .drive_en (drive_en),
      .report_en(report_en)
   );

   perr_detect #(.EARLY_ASSERT(EARLY_ASSERT)) u_det (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (start_ok),
      .live    (live),
      .ctx     (ctx),
      .resp_en (resp_en),
      .irdy_n  (irdy_n),
      .trdy_n  (trdy_n),
      .par_bad (par_bad),
      .assert_q(err_q)
   );

   assign perr_oe  = drive_en;
   assign perr_n_o = !(err_q && report_en);

   // R1: with response disabled the line reads high on the next clock
   assert_silent_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !resp_en |=> perr_n_o);

   // R8: the last driven clock before release is a high level
   assert_high_before_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(perr_oe) |-> $past(perr_n_o));

endmodule

// File: tb/sim_perr_signaller.sv
`timescale 1ns/1ps
module sim_perr_signaller;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic txn_start = 1'b0, dual_addr = 1'b0, is_master = 1'b0, is_write = 1'b0;
   logic special_cycle = 1'b0, resp_en = 1'b1;
   logic irdy_n = 1'b1, trdy_n = 1'b1, devsel_n = 1'b1, par_bad = 1'b0, ad_turn = 1'b0;
   logic perr_n_o, perr_oe;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   perr_signaller u0 (
      .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .dual_addr(dual_addr),
      .is_master(is_master), .is_write(is_write), .special_cycle(special_cycle),
      .resp_en(resp_en), .irdy_n(irdy_n), .trdy_n(trdy_n), .devsel_n(devsel_n),
      .par_bad(par_bad), .ad_turn(ad_turn), .perr_n_o(perr_n_o), .perr_oe(perr_oe)
   );

   // One clock: check outputs as the coming edge samples them, then drive inputs for that edge.
   task automatic cy(input logic st, input logic du, input logic ta, input logic ir,
                     input logic tr, input logic dv, input logic pb,
                     input logic eoe, input logic epn, input string rq);
      n_chk++;
      if (perr_oe !== eoe || perr_n_o !== epn) begin
         n_fail++;
         $display("FAIL %s: oe=%b perr_n=%b expected oe=%b perr_n=%b", rq, perr_oe, perr_n_o, eoe, epn);
      end
      txn_start = st; dual_addr = du; ad_turn = ta;
      irdy_n = ir; trdy_n = tr; devsel_n = dv; par_bad = pb;
      @(negedge clk);
   endtask

   task automatic ctx_set(input logic m, input logic w, input logic s, input logic en);
      is_master = m; is_write = w; special_cycle = s; resp_en = en;
   endtask

   // Single zero-wait data phase with bad parity; pn3 is the expected line at edge 3.
   task automatic t_single(input logic m, input logic w, input logic s, input logic en,
                           input logic pn3, input string rq);
      ctx_set(m, w, s, en);
      cy(1,0,0, 1,1,1,0, 0,1, "R11");
      cy(0,0,0, 0,0,0,0, 0,1, "R9");
      cy(0,0,1, 1,1,1,1, 0,1, "R9");
      cy(0,0,0, 1,1,1,0, 1,pn3, rq);
      cy(0,0,0, 1,1,1,0, 1,1, "R8");
      cy(0,0,0, 1,1,1,0, 0,1, "R8");
   endtask

   // R7 and R9: dual address, zero-wait burst of three, phases 1 and 3 bad
   task automatic t_burst;
      ctx_set(0, 1, 0, 1);
      cy(1,1,0, 1,1,1,0, 0,1, "R11");
      cy(0,0,0, 1,1,1,0, 0,1, "R9");
      cy(0,0,0, 0,0,0,0, 0,1, "R9");
      cy(0,0,0, 0,0,0,1, 0,1, "R9");
      cy(0,0,0, 0,0,0,0, 1,0, "R7");
      cy(0,0,1, 1,1,1,1, 1,1, "R7");
      cy(0,0,0, 1,1,1,0, 1,0, "R7");
      cy(0,0,0, 1,1,1,0, 1,1, "R8");
      cy(0,0,0, 1,1,1,0, 0,1, "R8");
   endtask

   // R5 and R6: receiver waits; only the first valid clock has bad parity
   task automatic t_wait(input logic m);
      ctx_set(m, !m, 0, 1);
      cy(1,0,0, 1,1,1,0, 0,1, "R11");
      cy(0,0,0, m,!m,0,0, 0,1, "R9");
      cy(0,0,0, m,!m,0,1, 0,1, "R9");
      cy(0,0,0, 0,0,0,0, 1,0, "R5");
      cy(0,0,1, 1,1,1,0, 1,0, "R6");
      cy(0,0,0, 1,1,1,0, 1,0, "R6");
      cy(0,0,0, 1,1,1,0, 1,1, "R8");
      cy(0,0,0, 1,1,1,0, 0,1, "R8");
   endtask

   // R10: target with slow decode claims on edge 3
   task automatic t_slow;
      ctx_set(0, 1, 0, 1);
      cy(1,0,0, 1,1,1,0, 0,1, "R11");
      cy(0,0,0, 0,1,1,0, 0,1, "R10");
      cy(0,0,0, 0,1,1,0, 0,1, "R10");
      cy(0,0,0, 0,0,0,0, 0,1, "R10");
      cy(0,0,1, 1,1,1,0, 1,1, "R10");
      cy(0,0,0, 1,1,1,0, 1,1, "R8");
      cy(0,0,0, 1,1,1,0, 1,1, "R8");
      cy(0,0,0, 1,1,1,0, 0,1, "R8");
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cy(0,0,0, 1,1,1,0, 0,1, "R11");
      t_single(1, 0, 0, 1, 1'b0, "R4");   // master read reports
      t_single(0, 1, 0, 1, 1'b0, "R4");   // target write reports
      t_single(1, 0, 0, 0, 1'b1, "R1");   // response disabled
      t_single(1, 1, 0, 1, 1'b1, "R2");   // master write: not the receiver
      t_single(0, 0, 0, 1, 1'b1, "R2");   // target read: not the receiver
      t_single(0, 1, 1, 1, 1'b1, "R3");   // special cycle
      t_burst;
      t_wait(1'b0);                        // target write, target waits
      t_wait(1'b1);                        // master read, master waits
      t_slow;
      cy(0,0,0, 1,1,1,0, 0,1, "R11");
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule